// File: doc/BRIEF.md
# Programmable High/Low Clock Divider

This block divides an incoming clock by a ratio set at run time. The divided period has two parts, a high part and a low part, and each part is given as an 8-bit count of input clock cycles. The division ratio is the sum of the two counts, and the duty cycle is the high count over that sum. When an odd ratio needs a duty cycle near one half, an odd-trim flag ends the high part half an input cycle early. The block does this by clearing the output on the falling input edge. A bypass flag routes the input clock straight to the output, which gives a ratio of one.

Software-side logic, or any other controller, presents new counts and flags together with a one-cycle load strobe. The block keeps the new values in a shadow copy. It moves them into the working copy only at the rising input edge where the next high part would begin, so the period in progress always finishes with the old values and no shortened pulse appears. A count of zero is treated as one. After reset the output is low, and the first rising input edge starts a high part using the reset settings (one high cycle, one low cycle).

Top module: `hl_clk_divider`

## Requirements
- R1: With trim and bypass off, the output is high for the first H and low for the next L input cycles of each period, where H and L are the active high and low counts. It changes only at rising input edges.
- R2: With trim on (bypass off), the output rises at the rising input edge that starts the period. It falls at the falling input edge in the middle of the H-th input cycle, so it is high for H−0.5 input cycles, then low until the next period starts.
- R3: With bypass active, the output equals the input clock.
- R4: A high or low count of zero is stored and used as one.
- R5: Values presented with the load strobe at a rising edge take effect at the first period start after that edge. The period in progress completes with its old counts and flags.
- R6: While reset is asserted the output is low. The first rising edge after release starts a high part, with reset settings H=1, L=1, trim off, bypass off.
- R7: Entering and leaving bypass happens only at a period start, which is a rising input edge where the output is going high in either mode, so no runt pulse occurs.
- R8: If several loads arrive before a period start, only the last one is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture strobe for the count and flag inputs |
| high_cnt_i | input | 8 | High-part length in input cycles (0 means 1) |
| low_cnt_i | input | 8 | Low-part length in input cycles (0 means 1) |
| bypass_i | input | 1 | Pass the input clock through unchanged |
| odd_i | input | 1 | End the high part half an input cycle early |
| clk_o | output | 1 | Divided clock |

## Verification
The hardest conditions to reach from the ports are the ones where a load lands part way through a long period, or where several loads land before one period start. In both cases the visible output must keep the old shape until the boundary. The stimulus deliberately strobes new values in the middle of high and low parts, and also strobes twice within one period. A reference model then predicts the output at both halves of every input cycle. This exposes half-cycle trim errors and early or late application of new settings, including the transitions into and out of bypass.

// File: rtl/hld_pkg.sv
package hld_pkg;

    localparam int HLD_CNT_W = 8;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

endpackage

// File: rtl/hld_settings.sv
module hld_settings #(
    parameter int W      = 8,
    parameter int RST_HI = 1,
    parameter int RST_LO = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    input  logic         byp_i,
    input  logic         odd_i,
    input  logic         boundary_i,
    output logic [W-1:0] act_hi_o,
    output logic [W-1:0] act_lo_o,
    output logic         act_byp_o,
    output logic         act_odd_o
);

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic         byp;
        logic         odd;
    } cfg_t;

    typedef struct packed {
        cfg_t shd;
        cfg_t act;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        // Boundary reads the shadow as it was before this edge's load.
        if (boundary_i) begin
            d.act = q.shd;
        end
        if (load_i) begin
            d.shd.hi  = (hi_i == '0) ? W'(1) : hi_i;
            d.shd.lo  = (lo_i == '0) ? W'(1) : lo_i;
            d.shd.byp = byp_i;
            d.shd.odd = odd_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.shd.hi  <= W'(RST_HI);
            q.shd.lo  <= W'(RST_LO);
            q.shd.byp <= 1'b0;
            q.shd.odd <= 1'b0;
            q.act.hi  <= W'(RST_HI);
            q.act.lo  <= W'(RST_LO);
            q.act.byp <= 1'b0;
            q.act.odd <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign act_hi_o  = q.act.hi;
    assign act_lo_o  = q.act.lo;
    assign act_byp_o = q.act.byp;
    assign act_odd_o = q.act.odd;

    assert_hold_until_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !boundary_i |=> $stable(q.act));

    assert_counts_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.act.hi != '0) && (q.act.lo != '0));

endmodule

// File: rtl/hld_counter.sv
module hld_counter #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] act_hi_i,
    input  logic [W-1:0] act_lo_i,
    input  logic         act_byp_i,
    output logic         boundary_o,
    output logic         high_o,
    output logic         last_high_o
);

    import hld_pkg::*;

    typedef struct packed {
        phase_e       ph;
        logic [W-1:0] cnt;
    } st_t;

    st_t q, d;
    logic lo_done;
    logic hi_done;

    always_comb begin
        lo_done    = (q.ph == PH_LOW)  && (q.cnt >= (act_lo_i - W'(1)));
        hi_done    = (q.ph == PH_HIGH) && (q.cnt >= (act_hi_i - W'(1)));
        boundary_o = act_byp_i || lo_done;
        d          = q;
        if (boundary_o) begin
            d.ph  = PH_HIGH;
            d.cnt = '0;
        end else if (hi_done) begin
            d.ph  = PH_LOW;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.ph  <= PH_LOW;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign high_o      = (q.ph == PH_HIGH);
    assign last_high_o = hi_done;

    assert_high_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.ph == PH_HIGH) |-> (q.cnt < act_hi_i));

    assert_low_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.ph == PH_LOW) |-> (q.cnt < act_lo_i));

endmodule

// File: rtl/hld_trim.sv
module hld_trim (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic act_byp_i,
    input  logic act_odd_i,
    input  logic high_i,
    input  logic last_high_i,
    output logic clk_o
);

    typedef struct packed {
        logic cut;
    } st_t;

    st_t q, d;

    always_comb begin
        d     = q;
        d.cut = act_odd_i && !act_byp_i && last_high_i;
    end

    // Falling-edge register: ends the high part half a cycle early.
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign clk_o = act_byp_i ? clk_i : (high_i && !q.cut);

    assert_trim_only_in_odd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.cut |-> (act_odd_i && !act_byp_i && high_i));

endmodule

// File: rtl/hl_clk_divider.sv
module hl_clk_divider #(
    parameter int CNT_W  = hld_pkg::HLD_CNT_W,
    parameter int RST_HI = 1,
    parameter int RST_LO = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] high_cnt_i,
    input  logic [CNT_W-1:0] low_cnt_i,
    input  logic             bypass_i,
    input  logic             odd_i,
    output logic             clk_o
);

    logic [CNT_W-1:0] act_hi;
    logic [CNT_W-1:0] act_lo;
    logic             act_byp;
    logic             act_odd;
    logic             boundary;
    logic             high;
    logic             last_high;

    hld_settings #(.W(CNT_W), .RST_HI(RST_HI), .RST_LO(RST_LO)) u_settings (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load_i),
        .hi_i       (high_cnt_i),
        .lo_i       (low_cnt_i),
        .byp_i      (bypass_i),
        .odd_i      (odd_i),
        .boundary_i (boundary),
        .act_hi_o   (act_hi),
        .act_lo_o   (act_lo),
        .act_byp_o  (act_byp),
        .act_odd_o  (act_odd)
    );

    hld_counter #(.W(CNT_W)) u_counter (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .act_hi_i    (act_hi),
        .act_lo_i    (act_lo),
        .act_byp_i   (act_byp),
        .boundary_o  (boundary),
        .high_o      (high),
        .last_high_o (last_high)
    );

    hld_trim u_trim (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .act_byp_i   (act_byp),
        .act_odd_i   (act_odd),
        .high_i      (high),
        .last_high_i (last_high),
        .clk_o       (clk_o)
    );

    assert_bypass_change_at_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_byp != $past(act_byp)) |-> high);

endmodule

// File: tb/tb_hl_clk_divider.sv
`timescale 1ns/1ps
module tb_hl_clk_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [7:0] hi = '0;
    logic [7:0] lo = '0;
    logic       byp = 1'b0;
    logic       odd = 1'b0;
    wire        clk_o;

    always #2 clk = ~clk;

    hl_clk_divider dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .load_i     (load),
        .high_cnt_i (hi),
        .low_cnt_i  (lo),
        .bypass_i   (byp),
        .odd_i      (odd),
        .clk_o      (clk_o)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    int s_hi = 1, s_lo = 1, s_byp = 0, s_odd = 0;
    int a_hi = 1, a_lo = 1, a_byp = 0, a_odd = 0;
    int in_high = 0, pos = 0;

    function automatic int nz(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic check(string req, logic got, logic exp, string half);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: clk_o=%b expected %b (%s half) at %0t", req, got, exp, half, $time);
        end
    endtask

    task automatic step_model(bit ld, int h, int l, bit b, bit o);
        if (a_byp != 0 || (in_high == 0 && pos >= a_lo - 1)) begin
            a_hi = s_hi; a_lo = s_lo; a_byp = s_byp; a_odd = s_odd;
            in_high = 1; pos = 0;
        end else if (in_high != 0) begin
            if (pos >= a_hi - 1) begin in_high = 0; pos = 0; end
            else pos++;
        end else begin
            pos++;
        end
        if (ld) begin
            s_hi = nz(h); s_lo = nz(l); s_byp = b; s_odd = o;
        end
    endtask

    task automatic cyc(string req, bit ld, int h, int l, bit b, bit o);
        logic e_hi, e_lo;
        load = ld; hi = h[7:0]; lo = l[7:0]; byp = b; odd = o;
        @(posedge clk);
        #1;
        if (rst_n) step_model(ld, h, l, b, o);
        if (!rst_n) begin e_hi = 0; e_lo = 0; end
        else if (a_byp != 0) begin e_hi = 1; e_lo = 0; end
        else begin
            e_hi = (in_high != 0);
            e_lo = (in_high != 0) && !(a_odd != 0 && pos == a_hi - 1);
        end
        check(req, clk_o, e_hi, "high");
        #2;
        check(req, clk_o, e_lo, "low");
        load = 0;
    endtask

    task automatic idle(string req, int n);
        for (int i = 0; i < n; i++) cyc(req, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #3;
        // R6: output low during reset, load ignored
        for (int i = 0; i < 3; i++) cyc("R6", 1, 7, 7, 1, 1);
        rst_n = 1'b1;
        idle("R6", 6);

        // R1: plain division 3/2, load mid-period
        cyc("R1", 1, 3, 2, 0, 0);
        idle("R1", 15);

        // R5: load arrives mid-period; current period keeps old shape
        idle("R5", 1);
        cyc("R5", 1, 4, 4, 0, 0);
        idle("R5", 20);

        // R2: trimmed high part
        cyc("R2", 1, 3, 2, 0, 1);
        idle("R2", 16);
        cyc("R2", 1, 1, 2, 0, 1);
        idle("R2", 12);
        cyc("R2", 1, 4, 3, 0, 1);
        idle("R2", 20);

        // R3/R7: enter bypass mid-period, run, leave
        cyc("R7", 1, 5, 3, 1, 0);
        idle("R7", 10);
        idle("R3", 8);
        cyc("R7", 1, 2, 2, 0, 0);
        idle("R7", 10);

        // R4: zero counts act as one
        cyc("R4", 1, 0, 0, 0, 0);
        idle("R4", 10);
        cyc("R4", 1, 0, 3, 0, 0);
        idle("R4", 12);

        // R8: two loads within one long period, last wins
        cyc("R8", 1, 6, 1, 0, 0);
        idle("R8", 6);
        cyc("R8", 1, 9, 9, 0, 0);
        cyc("R8", 1, 2, 5, 0, 0);
        idle("R8", 24);

        // R1: large counts
        cyc("R1", 1, 20, 7, 0, 0);
        idle("R1", 60);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule